// File: doc/BRIEF.md
# Polynomial Nonlinear Receiver Equalizer

This block cleans up nonlinear distortion in a single real stream of receiver samples. One 12-bit sample can enter on each clock, qualified by a valid strobe. The sample comes in offset-binary code. The block converts it to signed form and builds its square, cube and fourth power as 12-bit fractional words. Each power goes through its own short FIR filter with programmable coefficients. The filter results are rescaled by shifting and added to a delay-matched copy of the linear sample. The sum is clamped to the 12-bit output range.

A valid bit travels with the data through six register stages, so each result appears a fixed number of cycles after its input. Between results the output holds its last value. Coefficients are loaded through a small write port and hold their values through reset. When all coefficients are zero the block is a plain delay line: it passes the converted input through unchanged.

Top module: `poly_rx_eq`

## Requirements
- R1: The input code is offset binary. The signed sample x is the input with its most significant bit inverted, so code 0x800 gives 0, 0x000 gives -2048 and 0xFFF gives +2047.
- R2: `out_valid` is high in exactly the cycles that come 6 clock cycles after a cycle in which `in_valid` was high, and low in all other cycles.
- R3: While `out_valid` is low, `out_sample` keeps the value it last had.
- R4: The power terms are p2 = sat((x*x) >>> 11), p3 = sat((p2*x) >>> 11) and p4 = sat((p2*p2) >>> 11). sat() clamps to [-2048, 2047] and >>> is an arithmetic right shift.
- R5: For each power p in {x, p2, p3, p4}, the filter value is the sum over k = 0..3 of c[p][k] times that power from the k-th previous valid sample (k = 0 is the current sample). Cycles without a valid input do not advance the filter history.
- R6: A write with `cfg_we` high stores `cfg_data` as a signed Q1.11 coefficient. `cfg_addr[3:2]` selects the power (0 = x, 1 = p2, 2 = p3, 3 = p4) and `cfg_addr[1:0]` selects the tap k.
- R7: Each filter value is scaled to sat(value >>> 11). The output is sat(x + the four scaled terms), clamped to [-2048, 2047] rather than wrapped.
- R8: A synchronous active-high `rst` clears the valid pipeline, the filter histories and the output to zero, and leaves the stored coefficients unchanged.
- R9: With all sixteen coefficients at zero, each output equals the converted input sample from 6 cycles earlier.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Marks `in_raw` as a sample this cycle |
| in_raw | input | 12 | Input sample, offset binary |
| cfg_we | input | 1 | Coefficient write strobe |
| cfg_addr | input | 4 | Coefficient select: power in [3:2], tap in [1:0] |
| cfg_data | input | 12 | Coefficient value, signed Q1.11 |
| out_valid | output | 1 | Marks `out_sample` as a new result |
| out_sample | output | 12 | Corrected sample, two's complement |

## Verification
The bound checker watches the cycle-level rules on every clock. These are the six-cycle valid alignment, the output holding between results, the cleared outputs right after reset, and exact pass-through whenever it can see that every coefficient has been zero long enough. The arithmetic cannot be seen from the ports alone: the power truncation, tap ordering across gaps in the valid strobe, the scaling and the clamping at both rails. The bench covers these by sweeping every input code and comparing each result against an integer model under several coefficient sets. It also shows, through the filter output after a mid-stream reset, that coefficients survive reset while the histories do not.

// File: rtl/poly_eq_pkg.sv
package poly_eq_pkg;

    localparam int DW      = 12;
    localparam int TAPS    = 4;
    localparam int NPOW    = 4;
    localparam int FRAC    = DW - 1;
    localparam int WIDE_W  = 2 * DW + 8;
    localparam int LATENCY = 6;
    localparam int LIN_DLY = 2;
    localparam int TAP_AW  = $clog2(TAPS);
    localparam int POW_AW  = $clog2(NPOW);
    localparam int CA_W    = TAP_AW + POW_AW;

    typedef logic signed [DW-1:0]     word_t;
    typedef logic signed [WIDE_W-1:0] wide_t;
    typedef logic [NPOW-1:0][DW-1:0]  pow_vec_t;
    typedef logic [TAPS-1:0][DW-1:0]  coef_vec_t;

    typedef struct packed {
        logic  valid;
        word_t x;
    } samp_t;

    typedef struct packed {
        logic  valid;
        word_t x;
        word_t sq;
    } sq_stage_t;

    typedef struct packed {
        logic     valid;
        pow_vec_t pw;
    } pow_bus_t;

    localparam wide_t WORD_MAX = wide_t'((2 ** (DW - 1)) - 1);
    localparam wide_t WORD_MIN = -wide_t'(2 ** (DW - 1));

    function automatic word_t sat_word(input wide_t v);
        if (v > WORD_MAX) begin
            return word_t'(WORD_MAX);
        end else if (v < WORD_MIN) begin
            return word_t'(WORD_MIN);
        end
        return word_t'(v);
    endfunction

    function automatic word_t from_offset(input logic [DW-1:0] raw);
        return word_t'({~raw[DW-1], raw[DW-2:0]});
    endfunction

    function automatic word_t scaled_mul(input word_t a, input word_t b);
        wide_t prod;
        prod = wide_t'(a) * wide_t'(b);
        return sat_word(prod >>> FRAC);
    endfunction

endpackage

// File: rtl/poly_eq_powers.sv
module poly_eq_powers
    import poly_eq_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  logic          in_valid,
    input  logic [DW-1:0] in_raw,
    output pow_bus_t      pow_o
);

    samp_t     s1;
    sq_stage_t s2;

    // Stage 1: code conversion
    always_ff @(posedge clk) begin
        if (rst) begin
            s1 <= '0;
        end else begin
            s1.valid <= in_valid;
            if (in_valid) begin
                s1.x <= from_offset(in_raw);
            end
        end
    end

    // Stage 2: square
    always_ff @(posedge clk) begin
        if (rst) begin
            s2 <= '0;
        end else begin
            s2.valid <= s1.valid;
            s2.x     <= s1.x;
            s2.sq    <= scaled_mul(s1.x, s1.x);
        end
    end

    // Stage 3: cube and fourth power, all four terms aligned
    always_ff @(posedge clk) begin
        if (rst) begin
            pow_o <= '0;
        end else begin
            pow_o.valid <= s2.valid;
            pow_o.pw[0] <= s2.x;
            pow_o.pw[1] <= s2.sq;
            pow_o.pw[2] <= scaled_mul(s2.sq, s2.x);
            pow_o.pw[3] <= scaled_mul(s2.sq, s2.sq);
        end
    end

endmodule

// File: rtl/poly_eq_fir_pe.sv
module poly_eq_fir_pe
    import poly_eq_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      adv,
    input  word_t     din,
    input  coef_vec_t coef,
    output word_t     term
);

    word_t hist [TAPS-1];
    wide_t sum_c;
    wide_t sum_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < TAPS - 1; j++) begin
                hist[j] <= '0;
            end
        end else if (adv) begin
            hist[0] <= din;
            for (int j = 1; j < TAPS - 1; j++) begin
                hist[j] <= hist[j-1];
            end
        end
    end

    always_comb begin
        sum_c = wide_t'(din) * wide_t'(word_t'(coef[0]));
        for (int k = 1; k < TAPS; k++) begin
            sum_c = sum_c + wide_t'(hist[k-1]) * wide_t'(word_t'(coef[k]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sum_q <= '0;
            term  <= '0;
        end else begin
            sum_q <= sum_c;
            term  <= sat_word(sum_q >>> FRAC);
        end
    end

endmodule

// File: rtl/poly_eq_delay_pe.sv
module poly_eq_delay_pe
    import poly_eq_pkg::*;
#(
    parameter int DEPTH = LIN_DLY
) (
    input  logic  clk,
    input  logic  rst,
    input  word_t din,
    output word_t dout
);

    word_t line [DEPTH];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int j = 0; j < DEPTH; j++) begin
                line[j] <= '0;
            end
        end else begin
            line[0] <= din;
            for (int j = 1; j < DEPTH; j++) begin
                line[j] <= line[j-1];
            end
        end
    end

    assign dout = line[DEPTH-1];

endmodule

// File: rtl/poly_eq_accum.sv
module poly_eq_accum
    import poly_eq_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     in_valid,
    input  word_t    lin,
    input  pow_vec_t terms,
    output logic     out_valid,
    output word_t    out_sample
);

    wide_t total;

    always_comb begin
        total = wide_t'(lin);
        for (int k = 0; k < NPOW; k++) begin
            total = total + wide_t'(word_t'(terms[k]));
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            out_valid  <= 1'b0;
            out_sample <= '0;
        end else begin
            out_valid <= in_valid;
            if (in_valid) begin
                out_sample <= sat_word(total);
            end
        end
    end

endmodule

// File: rtl/poly_rx_eq.sv
module poly_rx_eq
    import poly_eq_pkg::*;
(
    input  logic            clk,
    input  logic            rst,
    input  logic            in_valid,
    input  logic [DW-1:0]   in_raw,
    input  logic            cfg_we,
    input  logic [CA_W-1:0] cfg_addr,
    input  logic [DW-1:0]   cfg_data,
    output logic            out_valid,
    output logic [DW-1:0]   out_sample
);

    pow_bus_t  pw3;
    coef_vec_t coef_bank [NPOW];
    pow_vec_t  term5;
    word_t     lin5;
    word_t     acc_out;
    logic      v4;
    logic      v5;

    // Coefficient store: not reset, survives rst
    always_ff @(posedge clk) begin
        if (cfg_we) begin
            coef_bank[cfg_addr[CA_W-1:TAP_AW]][cfg_addr[TAP_AW-1:0]] <= cfg_data;
        end
    end

    poly_eq_powers u_pow (
        .clk      (clk),
        .rst      (rst),
        .in_valid (in_valid),
        .in_raw   (in_raw),
        .pow_o    (pw3)
    );

    for (genvar p = 0; p < NPOW; p++) begin : g_pe
        poly_eq_fir_pe u_pe (
            .clk  (clk),
            .rst  (rst),
            .adv  (pw3.valid),
            .din  (word_t'(pw3.pw[p])),
            .coef (coef_bank[p]),
            .term (term5[p])
        );
    end

    poly_eq_delay_pe #(.DEPTH(LIN_DLY)) u_lin (
        .clk  (clk),
        .rst  (rst),
        .din  (word_t'(pw3.pw[0])),
        .dout (lin5)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            v4 <= 1'b0;
            v5 <= 1'b0;
        end else begin
            v4 <= pw3.valid;
            v5 <= v4;
        end
    end

    poly_eq_accum u_acc (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (v5),
        .lin        (lin5),
        .terms      (term5),
        .out_valid  (out_valid),
        .out_sample (acc_out)
    );

    assign out_sample = acc_out;

endmodule

// File: rtl/poly_rx_eq_chk.sv
module poly_rx_eq_chk
    import poly_eq_pkg::*;
(
    input logic            clk,
    input logic            rst,
    input logic            in_valid,
    input logic [DW-1:0]   in_raw,
    input logic            cfg_we,
    input logic [CA_W-1:0] cfg_addr,
    input logic [DW-1:0]   cfg_data,
    input logic            out_valid,
    input logic [DW-1:0]   out_sample
);

    logic [LATENCY-1:0]     vpipe;
    logic [DW-1:0]          xpipe [LATENCY];
    logic [NPOW*TAPS-1:0]   nonzero = '1;
    logic [3:0]             quiet = '0;

    always_ff @(posedge clk) begin
        if (rst) begin
            vpipe <= '0;
        end else begin
            vpipe <= {vpipe[LATENCY-2:0], in_valid};
        end
    end

    always_ff @(posedge clk) begin
        xpipe[0] <= in_raw;
        for (int j = 1; j < LATENCY; j++) begin
            xpipe[j] <= xpipe[j-1];
        end
    end

    always_ff @(posedge clk) begin
        if (cfg_we) begin
            nonzero[cfg_addr] <= (cfg_data != '0);
        end
    end

    always_ff @(posedge clk) begin
        if (nonzero != '0) begin
            quiet <= '0;
        end else if (quiet < 4'(LATENCY)) begin
            quiet <= quiet + 4'd1;
        end
    end

    p_latency_r2: assert property (@(posedge clk) disable iff (rst)
        out_valid == vpipe[LATENCY-1]);

    p_hold_r3: assert property (@(posedge clk) disable iff (rst)
        (!out_valid && !$past(rst)) |-> $stable(out_sample));

    p_reset_r8: assert property (@(posedge clk)
        $past(rst) |-> (!out_valid && out_sample == '0));

    p_bypass_r9: assert property (@(posedge clk) disable iff (rst)
        (out_valid && quiet == 4'(LATENCY)) |->
            (out_sample == from_offset(xpipe[LATENCY-1])));

endmodule

bind poly_rx_eq poly_rx_eq_chk u_chk (.*);

// File: tb/poly_rx_eq_test.sv
module poly_rx_eq_test;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] in_raw = '0;
    logic        cfg_we = 1'b0;
    logic [3:0]  cfg_addr = '0;
    logic [11:0] cfg_data = '0;
    logic        out_valid;
    logic [11:0] out_sample;

    poly_rx_eq uut (
        .clk        (clk),
        .rst        (rst),
        .in_valid   (in_valid),
        .in_raw     (in_raw),
        .cfg_we     (cfg_we),
        .cfg_addr   (cfg_addr),
        .cfg_data   (cfg_data),
        .out_valid  (out_valid),
        .out_sample (out_sample)
    );

    always #10 clk = ~clk;   // 50 MHz

    int    n_tests = 0;
    int    n_fail  = 0;
    int    cyc     = 0;
    string tag     = "R1";
    int    cm   [4][4];
    int    hist [4][3];
    int    exp_val [$];
    int    exp_due [$];
    int    last_out = 0;
    logic [15:0] lfsr = 16'hACE1;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int sat12(input int v);
        if (v > 2047) return 2047;
        if (v < -2048) return -2048;
        return v;
    endfunction

    function automatic int conv(input logic [11:0] raw);
        int v;
        v = int'(raw ^ 12'h800);
        if (v >= 2048) v = v - 4096;
        return v;
    endfunction

    // Bench model of one accepted sample; advances filter histories
    function automatic int model(input logic [11:0] raw);
        int x, pw[4], acc, tot;
        x = conv(raw);
        pw[0] = x;
        pw[1] = sat12((x * x) >>> 11);
        pw[2] = sat12((pw[1] * x) >>> 11);
        pw[3] = sat12((pw[1] * pw[1]) >>> 11);
        tot = x;
        for (int p = 0; p < 4; p++) begin
            acc = cm[p][0] * pw[p];
            for (int k = 1; k < 4; k++) acc = acc + cm[p][k] * hist[p][k-1];
            tot = tot + sat12(acc >>> 11);
            hist[p][2] = hist[p][1];
            hist[p][1] = hist[p][0];
            hist[p][0] = pw[p];
        end
        return sat12(tot);
    endfunction

    task automatic check(input string req, input int act, input int expv);
        n_tests++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d (cycle %0d)", req, act, expv, cyc);
        end
    endtask

    // Monitor, away from the active edge
    always @(negedge clk) begin
        if (rst) begin
            last_out = 0;
        end else begin
            if (exp_due.size() > 0 && exp_due[0] == cyc) begin
                check("R2 valid", int'(out_valid), 1);
                check(tag, int'($signed(out_sample)), exp_val[0]);
                void'(exp_due.pop_front());
                void'(exp_val.pop_front());
            end else begin
                check("R2 idle", int'(out_valid), 0);
                check("R3 hold", int'($signed(out_sample)), last_out);
            end
            last_out = int'($signed(out_sample));
        end
    end

    function automatic logic [15:0] step(input logic [15:0] s);
        return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
    endfunction

    task automatic send(input logic [11:0] raw);
        @(posedge clk); #1;
        in_valid = 1'b1;
        in_raw   = raw;
        exp_val.push_back(model(raw));
        exp_due.push_back(cyc + 6);
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk); #1;
            in_valid = 1'b0;
            in_raw   = 12'h5A5;
        end
    endtask

    task automatic wcoef(input int p, input int k, input int v);
        @(posedge clk); #1;
        in_valid = 1'b0;
        cfg_we   = 1'b1;
        cfg_addr = 4'(p * 4 + k);
        cfg_data = 12'(v);
        cm[p][k] = v;
        @(posedge clk); #1;
        cfg_we = 1'b0;
    endtask

    task automatic do_reset();
        @(posedge clk); #1;
        in_valid = 1'b0;
        rst = 1'b1;
        exp_val.delete();
        exp_due.delete();
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 3; k++) hist[p][k] = 0;
        repeat (3) @(posedge clk);
        #1 rst = 1'b0;
        @(negedge clk);
        // R8: cleared outputs just after reset
        check("R8 valid", int'(out_valid), 0);
        check("R8 data", int'($signed(out_sample)), 0);
    endtask

    task automatic set_all(input int v00, input int scale);
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++) wcoef(p, k, 0);
        if (scale != 0) wcoef(0, 0, v00);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        for (int p = 0; p < 4; p++)
            for (int k = 0; k < 4; k++) cm[p][k] = 0;
        do_reset();

        // R9 and R1: zero coefficients, every input code back to back
        set_all(0, 0);
        idle(8);
        tag = "R9/R1 bypass";
        for (int c = 0; c < 4096; c++) send(12'(c));
        idle(10);

        // R7 and R6: linear tap 0 at 0.5, output rails
        tag = "R7/R6 linear gain";
        wcoef(0, 0, 1024);
        idle(8);
        for (int c = 0; c < 4096; c += 5) begin
            send(12'(c));
            if ((c % 3) == 0) idle(1);
        end
        send(12'hFFF);
        send(12'h000);
        idle(10);

        // R5 and R6: tap ordering through gaps, single tap 3 then tap 2
        tag = "R5/R6 tap order";
        wcoef(0, 0, 0);
        wcoef(0, 3, 2047);
        wcoef(1, 2, -1500);
        idle(8);
        for (int i = 0; i < 40; i++) begin
            send(12'(i * 97 + 300));
            idle(i % 4);
        end
        idle(10);

        // R4 and R5: all branches active, pseudo-random codes and gaps
        tag = "R4/R5 nonlinear";
        wcoef(0, 0, 300);  wcoef(0, 1, -150); wcoef(0, 2, 80);   wcoef(0, 3, -40);
        wcoef(1, 0, -500); wcoef(1, 1, 200);  wcoef(1, 2, -100); wcoef(1, 3, 50);
        wcoef(2, 0, 700);  wcoef(2, 1, -300); wcoef(2, 2, 120);  wcoef(2, 3, 0);
        wcoef(3, 0, -900); wcoef(3, 1, 400);  wcoef(3, 2, 0);    wcoef(3, 3, -60);
        idle(8);
        for (int i = 0; i < 3000; i++) begin
            lfsr = step(lfsr);
            send(lfsr[11:0]);
            if (lfsr[15:14] == 2'b00) idle(int'(lfsr[13:12]) + 1);
        end
        idle(2);

        // R8: reset with samples in flight; coefficients kept, history cleared
        tag = "R8 after reset";
        send(12'h123);
        send(12'hE00);
        do_reset();
        for (int i = 0; i < 200; i++) begin
            lfsr = step(lfsr);
            send(lfsr[11:0]);
            if (lfsr[0]) idle(1);
        end
        idle(12);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

endmodule